// File: doc/BRIEF.md
# I2C Master Command Engine

This block runs I2C master transfers on behalf of software. Software writes a command word holding a byte count and control flags, and marks it runnable. The engine then issues a START if asked, a sequence of byte phases, and an optional STOP. Payload moves through a 32-bit data register. Four bytes are packed per word, and the lowest byte travels first. A data-request flag paces software: the engine raises it when it needs the next transmit word or has a received word ready, and software lowers it after each data access.

Wire-level SCL/SDA timing is not part of this block. Each bus phase is handed to a separate timing generator as a request/acknowledge operation (START, byte write, byte read, STOP). The generator returns the received byte, whether the slave acknowledged, and whether arbitration was lost.

A read is two commands. A one-byte select command sends the address with the R/W bit set, keeps the clock held and sends no STOP. A receive command without START then continues the bus. When the slave does not acknowledge, the engine halts until software writes a dedicated release bit.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, every register reads zero, `phy_req`, `irq` and `scl_hold` are low.
- R2: Register word addresses are: 0 command, 1 command-set, 2 command-clear, 3 control, 4 control-set, 5 control-clear, 6 status (read only), 7 data, 8 request-acknowledge (any write lowers the data-request flag). A set alias ORs the written ones in, a clear alias removes them, and other bits are untouched. Control holds flags in [7:0] and enables in [15:8]. Status holds bus-busy in bit 0, clock-busy in bit 1 and data-request in bit 2.
- R3: The command word holds a byte count in [15:0], transmit in bit 16, master in bit 17, START-first in bit 19, STOP-after in bit 20, hold-clock in bit 21, NAK-last in bit 25 and RUN in bit 29. A command runs only when master and RUN are set. Transmit bytes are issued lowest lane first. The address byte counts as one byte. On completion, flag bit 6 is set and RUN clears.
- R4: In transmit, data-request rises whenever a new word is needed, and no byte phase starts until software lowers the flag.
- R5: Received bytes are packed lowest lane first. The unused upper lanes of a partial last word read zero. With NAK-last set, only the final read phase asks the generator to NAK.
- R6: Bus-busy rises when a START completes. Bus-busy and clock-busy stay high until the STOP phase is acknowledged. At that point bus-busy falls and flag bit 7 (bus free) is set.
- R7: A slave NAK during transmit sets flag bit 5, clears RUN, and halts with no STOP. The engine stays busy until bit 28 is written as 1 to control (plain or set alias), and then it becomes idle with bus-busy low.
- R8: Command register writes made while the engine is not idle change nothing except bit 31.
- R9: With hold-clock set and STOP-after clear, `scl_hold` is high after completion until the next command starts.
- R10: `irq` is high exactly when some flag in [7:0] has its enable 8 bits above it set.
- R11: Command bit 31 holds the engine idle, lowers data-request and the busy bits, and clears all flags.
- R12: An arbitration loss reported with any phase sets flag bit 2, clears RUN and bus-busy, and ends the command without STOP.
- R13: With START-first clear, the command begins directly with its byte phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| phy_req | output | 1 | Bus phase request to the timing generator |
| phy_op | output | 2 | Phase: 0 START, 1 write byte, 2 read byte, 3 STOP |
| phy_tx_byte | output | 8 | Byte to transmit |
| phy_tx_nak | output | 1 | NAK the byte being read |
| phy_ack | input | 1 | Phase finished (one-cycle pulse) |
| phy_rx_byte | input | 8 | Byte read from the bus |
| phy_rx_nak | input | 1 | Slave did not acknowledge the written byte |
| phy_lost | input | 1 | Arbitration lost during the phase |
| scl_hold | output | 1 | Clock held low between chained commands |

## Verification
The block has a fixed register format and no tuning parameters, so the bench builds the single default configuration. It chooses transfer lengths that reach the interesting packing cases. A six-byte write and a six-byte read cross one word boundary and end on a two-lane partial word. A one-byte select exercises the held-clock chain into a receive without START. The timing-generator model answers each phase after a fixed delay, and it can inject a slave NAK or an arbitration loss on chosen phases.

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        phy_req,
  output logic [1:0]  phy_op,
  output logic [7:0]  phy_tx_byte,
  output logic        phy_tx_nak,
  input  logic        phy_ack,
  input  logic [7:0]  phy_rx_byte,
  input  logic        phy_rx_nak,
  input  logic        phy_lost,
  output logic        scl_hold
);
  localparam logic [1:0] OP_START = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DISP, S_LOADW, S_BYTE, S_RXW, S_STOP, S_HALT} st_t;
  st_t st;

  logic [31:0] cmd, data_reg, wbuf, cmd_sw, rx_word;
  logic [15:0] ctl, ctl_sw, cnt;
  logic [1:0]  lane;
  logic        dreq, bus_busy;

  wire sel_cmd  = reg_wr && (reg_addr <= 4'd2);
  wire sel_ctl  = reg_wr && (reg_addr >= 4'd3) && (reg_addr <= 4'd5);
  wire clr_nak  = sel_ctl && (reg_addr != 4'd5) && reg_wdata[28];
  wire idle     = (st == S_IDLE);
  wire srst     = cmd[31];
  wire tx       = cmd[16];
  wire go       = idle && cmd[29] && cmd[17] && !srst;
  wire last     = (cnt == 16'd1);
  wire wrap     = (lane == 2'd3);
  wire clk_busy = !idle || scl_hold;

  always_comb begin
    case (reg_addr)
      4'd1:    cmd_sw = cmd | reg_wdata;
      4'd2:    cmd_sw = cmd & ~reg_wdata;
      default: cmd_sw = reg_wdata;
    endcase
    case (reg_addr)
      4'd4:    ctl_sw = ctl | reg_wdata[15:0];
      4'd5:    ctl_sw = ctl & ~reg_wdata[15:0];
      default: ctl_sw = reg_wdata[15:0];
    endcase
    rx_word = wbuf;
    rx_word[{lane, 3'b000} +: 8] = phy_rx_byte;
    case (reg_addr)
      4'd0, 4'd1, 4'd2: reg_rdata = cmd;
      4'd3, 4'd4, 4'd5: reg_rdata = {16'd0, ctl};
      4'd6:             reg_rdata = {29'd0, dreq, clk_busy, bus_busy};
      4'd7:             reg_rdata = data_reg;
      default:          reg_rdata = 32'd0;
    endcase
  end

  assign phy_tx_byte = wbuf[{lane, 3'b000} +: 8];
  assign irq = |(ctl[7:0] & ctl[15:8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd <= '0; ctl <= '0; data_reg <= '0; wbuf <= '0; cnt <= '0;
      lane <= '0; dreq <= 1'b0; bus_busy <= 1'b0; scl_hold <= 1'b0;
      phy_req <= 1'b0; phy_op <= OP_START; phy_tx_nak <= 1'b0;
    end else begin
      if (sel_cmd) cmd <= idle ? cmd_sw : {cmd_sw[31], cmd[30:0]};
      if (sel_ctl) ctl <= ctl_sw;
      if (reg_wr && reg_addr == 4'd7) data_reg <= reg_wdata;
      if (reg_wr && reg_addr == 4'd8) dreq <= 1'b0;
      if (srst) begin
        st <= S_IDLE; phy_req <= 1'b0; dreq <= 1'b0; bus_busy <= 1'b0;
        scl_hold <= 1'b0; ctl[7:0] <= '0; cmd[29] <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (go) begin
            cnt <= cmd[15:0]; lane <= '0; wbuf <= '0; scl_hold <= 1'b0;
            st <= cmd[19] ? S_START : S_DISP;
          end
          S_START: begin
            if (!phy_req) begin
              phy_req <= 1'b1; phy_op <= OP_START;
            end else if (phy_ack) begin
              phy_req <= 1'b0;
              if (phy_lost) begin
                ctl[2] <= 1'b1; cmd[29] <= 1'b0; bus_busy <= 1'b0; st <= S_IDLE;
              end else begin
                bus_busy <= 1'b1; st <= S_DISP;
              end
            end
          end
          S_DISP: begin
            if (cnt == 16'd0) begin
              if (cmd[20]) st <= S_STOP;
              else begin ctl[6] <= 1'b1; cmd[29] <= 1'b0; scl_hold <= cmd[21]; st <= S_IDLE; end
            end else if (tx) begin
              dreq <= 1'b1; st <= S_LOADW;
            end else st <= S_BYTE;
          end
          S_LOADW: if (!dreq) begin wbuf <= data_reg; st <= S_BYTE; end
          S_BYTE: begin
            if (!phy_req) begin
              phy_req <= 1'b1; phy_op <= tx ? OP_WR : OP_RD;
              phy_tx_nak <= !tx && last && cmd[25];
            end else if (phy_ack) begin
              phy_req <= 1'b0;
              if (phy_lost) begin
                ctl[2] <= 1'b1; cmd[29] <= 1'b0; bus_busy <= 1'b0; st <= S_IDLE;
              end else if (tx && phy_rx_nak) begin
                ctl[5] <= 1'b1; cmd[29] <= 1'b0; st <= S_HALT;
              end else begin
                cnt <= cnt - 16'd1; lane <= lane + 2'd1;
                if (tx) begin
                  if (last) begin
                    if (cmd[20]) st <= S_STOP;
                    else begin ctl[6] <= 1'b1; cmd[29] <= 1'b0; scl_hold <= cmd[21]; st <= S_IDLE; end
                  end else if (wrap) begin
                    dreq <= 1'b1; st <= S_LOADW;
                  end
                end else begin
                  wbuf <= rx_word;
                  if (last || wrap) begin data_reg <= rx_word; dreq <= 1'b1; st <= S_RXW; end
                end
              end
            end
          end
          S_RXW: if (!dreq) begin
            wbuf <= '0;
            if (cnt == 16'd0) begin
              if (cmd[20]) st <= S_STOP;
              else begin ctl[6] <= 1'b1; cmd[29] <= 1'b0; scl_hold <= cmd[21]; st <= S_IDLE; end
            end else st <= S_BYTE;
          end
          S_STOP: begin
            if (!phy_req) begin
              phy_req <= 1'b1; phy_op <= OP_STOP;
            end else if (phy_ack) begin
              phy_req <= 1'b0; bus_busy <= 1'b0; ctl[7] <= 1'b1; ctl[6] <= 1'b1;
              cmd[29] <= 1'b0; scl_hold <= 1'b0; st <= S_IDLE;
            end
          end
          S_HALT: if (clr_nak) begin st <= S_IDLE; bus_busy <= 1'b0; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !phy_ack && !srst |=> phy_req && $stable(phy_op) && $stable(phy_tx_byte));

  assert_nak_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && phy_op == OP_RD && phy_tx_nak |-> last && cmd[25]);

  assert_stop_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && phy_ack && phy_op == OP_STOP && !srst |=> !bus_busy && ctl[7]);

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_HALT |-> !phy_req && !cmd[29]);

  assert_busy_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && sel_cmd |=> {cmd[30], cmd[28:0]} == $past({cmd[30], cmd[28:0]}));

  assert_srst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> idle && !phy_req && !dreq && ctl[7:0] == 8'd0);
endmodule

// File: tb/tb_i2c_cmd_engine.sv
module tb_i2c_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, phy_req, phy_tx_nak, scl_hold;
  logic [1:0] phy_op;
  logic [7:0] phy_tx_byte;
  logic phy_ack = 1'b0, phy_rx_nak = 1'b0, phy_lost = 1'b0;
  logic [7:0] phy_rx_byte = '0;

  i2c_cmd_engine dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .phy_req(phy_req),
    .phy_op(phy_op), .phy_tx_byte(phy_tx_byte), .phy_tx_nak(phy_tx_nak), .phy_ack(phy_ack),
    .phy_rx_byte(phy_rx_byte), .phy_rx_nak(phy_rx_nak), .phy_lost(phy_lost), .scl_hold(scl_hold));

  always #10 clk = ~clk;

  localparam logic [31:0] C_TX = 32'h1 << 16, C_MST = 32'h1 << 17, C_PRE = 32'h1 << 19,
    C_POST = 32'h1 << 20, C_RET = 32'h1 << 21, C_NAKL = 32'h1 << 25, C_RUN = 32'h1 << 29,
    C_SRST = 32'h1 << 31;

  typedef struct packed { logic [1:0] op; logic [7:0] b; logic nak; logic lost; logic [3:0] rq; } item_t;
  item_t expq[$];
  int checks = 0, errors = 0, dly = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b, input logic nak,
                      input logic lost, input logic [3:0] rq);
    expq.push_back(item_t'{op: op, b: b, nak: nak, lost: lost, rq: rq});
  endtask

  // Monitor and timing-generator model: answers each phase after a fixed delay
  always @(negedge clk) begin
    item_t it;
    if (phy_ack) begin
      phy_ack = 1'b0; phy_lost = 1'b0; phy_rx_nak = 1'b0;
    end else if (!phy_req) dly = 0;
    else if (dly < 2) dly++;
    else begin
      dly = 0;
      if (expq.size() == 0) begin
        chk("R3 unexpected bus phase", {30'd0, phy_op}, 32'hFFFF_FFFF);
        it = '0;
      end else begin
        it = expq.pop_front();
        chk($sformatf("R%0d phase kind", it.rq), {30'd0, phy_op}, {30'd0, it.op});
        if (it.op == 2'd1) chk($sformatf("R%0d tx byte", it.rq), {24'd0, phy_tx_byte}, {24'd0, it.b});
        if (it.op == 2'd2) chk("R5 nak request", {31'd0, phy_tx_nak}, {31'd0, it.nak});
      end
      phy_rx_byte = it.b;
      phy_rx_nak  = (it.op == 2'd1) && it.nak;
      phy_lost    = it.lost;
      phy_ack     = 1'b1;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_bit(input logic [3:0] a, input int b, input string req);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); rd(a, v);
      if (v[b]) return;
    end
    chk({req, " wait timeout"}, 32'd0, 32'd1);
  endtask

  function automatic logic [31:0] pack(input logic [7:0] bq[$], input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (w * 4 + k < bq.size()) r[k*8 +: 8] = bq[w*4 + k];
    return r;
  endfunction

  task automatic send_words(input logic [7:0] bq[$]);
    for (int w = 0; w < (bq.size() + 3) / 4; w++) begin
      wait_bit(4'd6, 2, "R4");
      wr(4'd7, pack(bq, w));
      wr(4'd8, 32'd1);
    end
  endtask

  task automatic recv_words(input logic [7:0] bq[$]);
    logic [31:0] v;
    for (int w = 0; w < (bq.size() + 3) / 4; w++) begin
      wait_bit(4'd6, 2, "R5");
      rd(4'd7, v);
      chk("R5 received word", v, pack(bq, w));
      wr(4'd8, 32'd1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] bq[$];
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, v); chk("R1 command", v, 32'd0);
    rd(4'd3, v); chk("R1 control", v, 32'd0);
    rd(4'd6, v); chk("R1 status", v, 32'd0);
    chk("R1 outputs", {29'd0, phy_req, irq, scl_hold}, 32'd0);

    // R2 aliases
    wr(4'd4, 32'h0300); wr(4'd5, 32'h0100);
    rd(4'd3, v); chk("R2 control aliases", v, 32'h0200);
    wr(4'd0, 32'h5); wr(4'd1, C_TX); wr(4'd2, 32'h4);
    rd(4'd0, v); chk("R2 command aliases", v, C_TX | 32'h1);
    wr(4'd0, 32'd0); wr(4'd3, 32'd0);

    // R3 R4 R6 R8 write of five payload bytes with START and STOP
    bq = '{8'h74, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    push(2'd0, 0, 0, 0, 3);
    foreach (bq[i]) push(2'd1, bq[i], 0, 0, 3);
    push(2'd3, 0, 0, 0, 6);
    wr(4'd0, C_PRE | C_POST | C_TX | C_MST | C_RUN | 32'd6);
    wait_bit(4'd6, 2, "R4");
    repeat (10) @(negedge clk);
    chk("R4 no byte before data", expq.size(), 32'd7);
    rd(4'd6, v); chk("R6 busy while running", v, 32'h7);
    wr(4'd0, 32'h0000_00FF);
    send_words(bq);
    wait_bit(4'd3, 6, "R3");
    chk("R3 all phases seen", expq.size(), 32'd0);
    rd(4'd0, v); chk("R8 command kept, R3 run cleared", v, C_PRE | C_POST | C_TX | C_MST | 32'd6);
    rd(4'd6, v); chk("R6 busy low after stop", v, 32'd0);
    rd(4'd3, v); chk("R6 bus free and done flags", v, 32'h00C0);

    // R10 interrupt
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    wr(4'd4, 32'h4000); @(negedge clk);
    chk("R10 irq raised", {31'd0, irq}, 32'd1);
    wr(4'd5, 32'h0040); @(negedge clk);
    chk("R10 irq gone", {31'd0, irq}, 32'd0);
    wr(4'd3, 32'd0);

    // R9 R13 R5 read: select then receive
    bq = '{8'h75};
    push(2'd0, 0, 0, 0, 3); push(2'd1, 8'h75, 0, 0, 3);
    wr(4'd0, C_PRE | C_TX | C_RET | C_MST | C_RUN | 32'd1);
    send_words(bq);
    wait_bit(4'd3, 6, "R9");
    chk("R9 clock held", {31'd0, scl_hold}, 32'd1);
    rd(4'd6, v); chk("R9 status while held", v, 32'h3);
    wr(4'd3, 32'd0);
    bq = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6};
    foreach (bq[i]) push(2'd2, bq[i], (i == 5), 0, 13);
    push(2'd3, 0, 0, 0, 6);
    wr(4'd0, C_NAKL | C_POST | C_MST | C_RUN | 32'd6);
    repeat (3) @(negedge clk);
    chk("R9 hold released", {31'd0, scl_hold}, 32'd0);
    recv_words(bq);
    wait_bit(4'd3, 6, "R13");
    chk("R13 no START in receive", expq.size(), 32'd0);
    rd(4'd6, v); chk("R6 idle after receive", v, 32'd0);

    // R7 NAK halt
    wr(4'd3, 32'd0);
    bq = '{8'hA0, 8'h99};
    push(2'd0, 0, 0, 0, 7); push(2'd1, 8'hA0, 1, 0, 7);
    wr(4'd0, C_PRE | C_POST | C_TX | C_MST | C_RUN | 32'd2);
    send_words(bq);
    wait_bit(4'd3, 5, "R7");
    repeat (5) @(negedge clk);
    rd(4'd3, v); chk("R7 only no-ack flag", v, 32'h0020);
    rd(4'd6, v); chk("R7 halted busy", v, 32'h3);
    wr(4'd0, C_PRE | C_TX | C_MST | C_RUN | 32'd1);
    repeat (20) @(negedge clk);
    rd(4'd0, v); chk("R8 command ignored while halted", v, C_PRE | C_POST | C_TX | C_MST | 32'd2);
    chk("R7 no stop issued", expq.size(), 32'd0);
    wr(4'd4, 32'h1000_0000); @(negedge clk);
    rd(4'd6, v); chk("R7 released to idle", v, 32'd0);
    wr(4'd3, 32'd0);
    bq = '{8'hA0};
    push(2'd0, 0, 0, 0, 7); push(2'd1, 8'hA0, 0, 0, 7); push(2'd3, 0, 0, 0, 7);
    wr(4'd0, C_PRE | C_POST | C_TX | C_MST | C_RUN | 32'd1);
    send_words(bq);
    wait_bit(4'd3, 6, "R7");
    chk("R7 runs after release", expq.size(), 32'd0);

    // R12 arbitration loss
    wr(4'd3, 32'd0);
    push(2'd0, 0, 0, 1, 12);
    wr(4'd0, C_PRE | C_POST | C_TX | C_MST | C_RUN | 32'd3);
    wait_bit(4'd3, 2, "R12");
    repeat (5) @(negedge clk);
    rd(4'd3, v); chk("R12 loss flag only", v, 32'h0004);
    rd(4'd6, v); chk("R12 bus released", v, 32'd0);
    rd(4'd0, v); chk("R12 run cleared", v & C_RUN, 32'd0);
    chk("R12 no stop", expq.size(), 32'd0);

    // R11 soft reset mid-transfer
    push(2'd0, 0, 0, 0, 11);
    wr(4'd0, C_PRE | C_TX | C_MST | C_RUN | 32'd2);
    wait_bit(4'd6, 2, "R11");
    wr(4'd1, C_SRST); @(negedge clk);
    rd(4'd6, v); chk("R11 status cleared", v, 32'd0);
    rd(4'd3, v); chk("R11 flags cleared", v, 32'd0);
    rd(4'd0, v); chk("R11 reset bit held", v & (C_SRST | C_RUN), C_SRST);
    wr(4'd2, C_SRST);
    rd(4'd0, v); chk("R11 reset bit cleared", v & C_SRST, 32'd0);
    chk("R11 no request", {31'd0, phy_req}, 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule